// File: doc/BRIEF.md
# Maintenance Config Responder

This block answers single-word configuration maintenance requests that arrive as packets in an inbound frame buffer. It pulls the request one 32-bit word at a time and decodes the header, the device IDs, the transaction code and the offset. For a read or write request it runs one access on a local configuration bus. That bus has a strobe, a write enable, a 24-bit address, a byte select, 64-bit data in each direction and an acknowledge.

Once the access completes, the block builds the matching response packet and writes it word by word into an outbound frame buffer. It then commits the frame. The response swaps the two device IDs, returns the transaction tag unchanged, forces the hop count to all ones and clears the offset. Bit 2 of the address selects which 32-bit half of the 64-bit doubleword carries the word. This applies both on the bus and in the read payload.

The packet layout uses 32-bit words.
- Word 0: bits 31:27 ack field, 26 channel, 25 critical flag, 24:23 priority, 22:21 transport type, 20:17 format type, 16 reserved, 15:0 destination ID.
- Word 1: bits 31:16 source ID, 15:12 transaction, 11:8 size, 7:0 tag.
- Word 2: bits 31:24 hop count, 23:3 offset, 2 word pointer, 1:0 reserved.
- Data words follow, upper half first.

Top module: `maint_cfg_responder`

## Requirements
- R1: After reset every strobe output is low, and while the read port reports empty no word is taken.
- R2: Request words are taken until the end flag is seen, extra trailing words included. The frame is then released with exactly one frame-take pulse, issued only while the end flag is high.
- R3: A read request (format type 8, transaction 0000) raises `cfgStb` with `cfgWe` low. `cfgAddr` is {offset, pointer, 00}. `cfgSel` is 8'hF0 for pointer 0 and 8'h0F for pointer 1. All of these hold steady until `cfgAck`.
- R4: A write request (transaction 0001) raises `cfgStb` with `cfgWe` high. For pointer 0 the write data is {word,32'h0}, where the word is the first data word. For pointer 1 it is {32'h0,word}, where the word is the second data word.
- R5: A read response is five words: three header words, then a payload doubleword. For pointer 0 the payload is {read[63:32], 0}; for pointer 1 it is {0, read[31:0]}. The transaction is 0010 and the size is 0000.
- R6: A write response is three words with transaction 0011, size 0000 and no payload.
- R7: Response word 0 is 32'h0030_0000 plus the request's source ID in bits 15:0. Word 1 carries the request's destination ID in bits 31:16 and the request tag in bits 7:0. Word 2 is 32'hFF00_0000.
- R8: No response word is written while the write port reports full before the response starts.
- R9: A frame whose format type is not 8, whose transaction is neither 0000 nor 0001, or which is too short (fewer than 3 words for a read, fewer than 5 for a write) is consumed with no bus access and no response.
- R10: Each response is followed by a single commit pulse in the cycle after its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdFrameEmpty | input | 1 | No inbound frame present |
| rdWordData | input | 32 | Current inbound word |
| rdWordEnd | input | 1 | No more words in the current frame |
| rdWordTake | output | 1 | Advance to the next inbound word |
| rdFrameTake | output | 1 | Release the inbound frame |
| wrFull | input | 1 | Outbound buffer cannot accept a frame |
| wrWordPut | output | 1 | Write `wrWordData` into the outbound frame |
| wrWordData | output | 32 | Outbound word |
| wrFrameCommit | output | 1 | Commit the outbound frame |
| cfgStb | output | 1 | Config access strobe |
| cfgWe | output | 1 | Config write enable |
| cfgAddr | output | 24 | Config byte address |
| cfgSel | output | 8 | Config byte lanes |
| cfgWrData | output | 64 | Config write data |
| cfgRdData | input | 64 | Config read data |
| cfgAck | input | 1 | Config access done |

## Verification
The requests tried are reads and writes with the word pointer at both 0 and 1. This separates the upper-half path from the lower-half path on the bus, in the payload and in the write-data word selection. A request with a trailing extra word exercises the drain logic. A wrong format type, a wrong transaction code and a truncated write each exercise the drop path. The bus acknowledge comes only after the third strobe cycle, so held address and data are checked across several cycles. A response is also held back behind a full write port to show that the write waits.

// File: rtl/maint_pkg.sv
package maint_pkg;
  localparam int WORD_W     = 32;
  localparam int DW_W       = 2 * WORD_W;
  localparam int ADDR_W     = 24;
  localparam int SEL_W      = DW_W / 8;
  localparam int ID_W       = 16;
  localparam int REQ_WORDS  = 5;
  localparam int IDX_W      = 3;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  localparam logic [3:0] FTYPE_MAINT = 4'd8;
  localparam logic [1:0] TT_SMALL    = 2'b01;
  localparam logic [3:0] TR_READ     = 4'b0000;
  localparam logic [3:0] TR_WRITE    = 4'b0001;
  localparam logic [3:0] TR_READ_RSP = 4'b0010;
  localparam logic [3:0] TR_WRITE_RSP= 4'b0011;
  localparam logic [3:0] SIZE_NONE   = 4'b0000;
  localparam logic [7:0] HOP_RSP     = 8'hFF;

  localparam logic [IDX_W-1:0] READ_MIN_WORDS  = 3'd3;
  localparam logic [IDX_W-1:0] WRITE_MIN_WORDS = 3'd5;
  localparam logic [IDX_W-1:0] READ_RSP_LAST   = 3'd4;
  localparam logic [IDX_W-1:0] WRITE_RSP_LAST  = 3'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PULL, ST_RELEASE, ST_ACCESS, ST_WAITOUT, ST_EMIT, ST_COMMIT
  } ctlState_t;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] capIdx;
    logic             latchRead;
    logic [IDX_W-1:0] emitIdx;
  } ctlStrobes_t;
endpackage

// File: rtl/maint_dp.sv
module maint_dp
  import maint_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [WORD_W-1:0] rdWordData,
  input  logic [DW_W-1:0]   cfgRdData,
  output logic              reqOk,
  output logic              reqWrite,
  output logic [IDX_W-1:0]  reqMinWords,
  output logic [IDX_W-1:0]  respLastIdx,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic [SEL_W-1:0]  cfgSel,
  output logic [DW_W-1:0]   cfgWrData,
  output logic [WORD_W-1:0] wrWordData
);
  localparam logic [15:0] RSP_HEADER = {5'b0, 1'b0, 1'b0, 2'b00, TT_SMALL, FTYPE_MAINT, 1'b0};

  logic [WORD_W-1:0] reqWord [REQ_WORDS];
  logic [DW_W-1:0]   readHold;

  for (genvar g = 0; g < REQ_WORDS; g++) begin : gCapture
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) reqWord[g] <= '0;
      else if (ctl.capture && ctl.capIdx == IDX_W'(g)) reqWord[g] <= rdWordData;
    end
  end

  logic [3:0]      fType;
  logic [ID_W-1:0] destId, srcId;
  logic [3:0]      trans;
  logic [7:0]      tag;
  logic [20:0]     offset;
  logic            wordPtr;
  logic [WORD_W-1:0] dataWord;

  always_comb begin
    fType    = reqWord[0][20:17];
    destId   = reqWord[0][15:0];
    srcId    = reqWord[1][31:16];
    trans    = reqWord[1][15:12];
    tag      = reqWord[1][7:0];
    offset   = reqWord[2][23:3];
    wordPtr  = reqWord[2][2];
    dataWord = wordPtr ? reqWord[4] : reqWord[3];
  end

  assign reqWrite    = (trans == TR_WRITE);
  assign reqOk       = (fType == FTYPE_MAINT) && (trans == TR_READ || trans == TR_WRITE);
  assign reqMinWords = reqWrite ? WRITE_MIN_WORDS : READ_MIN_WORDS;
  assign respLastIdx = reqWrite ? WRITE_RSP_LAST : READ_RSP_LAST;

  assign cfgAddr   = {offset, wordPtr, 2'b00};
  assign cfgSel    = wordPtr ? 8'h0F : 8'hF0;
  assign cfgWrData = wordPtr ? {{WORD_W{1'b0}}, dataWord} : {dataWord, {WORD_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readHold <= '0;
    else if (ctl.latchRead)
      readHold <= wordPtr ? {{WORD_W{1'b0}}, cfgRdData[WORD_W-1:0]}
                          : {cfgRdData[DW_W-1:WORD_W], {WORD_W{1'b0}}};
  end

  always_comb begin
    case (ctl.emitIdx)
      3'd0:    wrWordData = {RSP_HEADER, srcId};
      3'd1:    wrWordData = {destId, (reqWrite ? TR_WRITE_RSP : TR_READ_RSP), SIZE_NONE, tag};
      3'd2:    wrWordData = {HOP_RSP, 24'h0};
      3'd3:    wrWordData = readHold[DW_W-1:WORD_W];
      3'd4:    wrWordData = readHold[WORD_W-1:0];
      default: wrWordData = '0;
    endcase
  end
endmodule

// File: rtl/maint_ctl.sv
module maint_ctl
  import maint_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdFrameEmpty,
  input  logic             rdWordEnd,
  input  logic             wrFull,
  input  logic             cfgAck,
  input  logic             reqOk,
  input  logic             reqWrite,
  input  logic [IDX_W-1:0] reqMinWords,
  input  logic [IDX_W-1:0] respLastIdx,
  output logic             rdWordTake,
  output logic             rdFrameTake,
  output logic             cfgStb,
  output logic             cfgWe,
  output logic             wrWordPut,
  output logic             wrFrameCommit,
  output ctlStrobes_t      ctl
);
  ctlState_t        state;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (!rdFrameEmpty) begin
          state <= ST_PULL;
          cnt   <= '0;
        end
        ST_PULL: begin
          if (rdWordEnd) state <= ST_RELEASE;
          else if (cnt != IDX_MAX) cnt <= cnt + 1'b1;
        end
        ST_RELEASE: state <= (reqOk && cnt >= reqMinWords) ? ST_ACCESS : ST_IDLE;
        ST_ACCESS:  if (cfgAck) state <= ST_WAITOUT;
        ST_WAITOUT: if (!wrFull) begin
          state <= ST_EMIT;
          cnt   <= '0;
        end
        ST_EMIT: begin
          if (cnt == respLastIdx) state <= ST_COMMIT;
          else cnt <= cnt + 1'b1;
        end
        ST_COMMIT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rdWordTake    = (state == ST_PULL) && !rdWordEnd;
    rdFrameTake   = (state == ST_RELEASE);
    cfgStb        = (state == ST_ACCESS);
    cfgWe         = (state == ST_ACCESS) && reqWrite;
    wrWordPut     = (state == ST_EMIT);
    wrFrameCommit = (state == ST_COMMIT);
    ctl.capture   = rdWordTake;
    ctl.capIdx    = cnt;
    ctl.latchRead = (state == ST_ACCESS) && cfgAck;
    ctl.emitIdx   = cnt;
  end
endmodule

// File: rtl/maint_cfg_responder.sv
module maint_cfg_responder
  import maint_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdFrameEmpty,
  input  logic [WORD_W-1:0] rdWordData,
  input  logic              rdWordEnd,
  output logic              rdWordTake,
  output logic              rdFrameTake,
  input  logic              wrFull,
  output logic              wrWordPut,
  output logic [WORD_W-1:0] wrWordData,
  output logic              wrFrameCommit,
  output logic              cfgStb,
  output logic              cfgWe,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic [SEL_W-1:0]  cfgSel,
  output logic [DW_W-1:0]   cfgWrData,
  input  logic [DW_W-1:0]   cfgRdData,
  input  logic              cfgAck
);
  ctlStrobes_t      ctl;
  logic             reqOk, reqWrite;
  logic [IDX_W-1:0] reqMinWords, respLastIdx;

  maint_ctl uCtl (
    .clk(clk), .rstN(rstN), .rdFrameEmpty(rdFrameEmpty), .rdWordEnd(rdWordEnd),
    .wrFull(wrFull), .cfgAck(cfgAck), .reqOk(reqOk), .reqWrite(reqWrite),
    .reqMinWords(reqMinWords), .respLastIdx(respLastIdx),
    .rdWordTake(rdWordTake), .rdFrameTake(rdFrameTake), .cfgStb(cfgStb),
    .cfgWe(cfgWe), .wrWordPut(wrWordPut), .wrFrameCommit(wrFrameCommit), .ctl(ctl)
  );

  maint_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdWordData(rdWordData), .cfgRdData(cfgRdData),
    .reqOk(reqOk), .reqWrite(reqWrite), .reqMinWords(reqMinWords),
    .respLastIdx(respLastIdx), .cfgAddr(cfgAddr), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .wrWordData(wrWordData)
  );
endmodule

// File: rtl/maint_cfg_checker.sv
module maint_cfg_checker
  import maint_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              rdFrameEmpty,
  input logic [WORD_W-1:0] rdWordData,
  input logic              rdWordEnd,
  input logic              rdWordTake,
  input logic              rdFrameTake,
  input logic              wrFull,
  input logic              wrWordPut,
  input logic [WORD_W-1:0] wrWordData,
  input logic              wrFrameCommit,
  input logic              cfgStb,
  input logic              cfgWe,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [SEL_W-1:0]  cfgSel,
  input logic [DW_W-1:0]   cfgWrData,
  input logic [DW_W-1:0]   cfgRdData,
  input logic              cfgAck
);
  assert_idle_waits_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdFrameEmpty && !rdWordTake && !rdFrameTake && !cfgStb && !wrWordPut && !wrFrameCommit)
      |=> !rdWordTake);

  assert_release_at_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdFrameTake |-> rdWordEnd);

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStb && !cfgAck) |=> (cfgStb && $stable(cfgAddr) && $stable(cfgWe)
                             && $stable(cfgSel) && $stable(cfgWrData)));

  assert_sel_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgStb |-> (cfgSel == (cfgAddr[2] ? 8'h0F : 8'hF0)));

  assert_no_start_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrWordPut) |-> $past(!wrFull));

  assert_commit_after_word_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrFrameCommit |-> $past(wrWordPut));

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdWordTake, rdFrameTake, cfgStb, wrWordPut, wrFrameCommit}));
endmodule

bind maint_cfg_responder maint_cfg_checker uChk (.*);

// File: tb/sim_maint_cfg_responder.sv
module sim_maint_cfg_responder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdFrameEmpty = 1'b1;
  logic [31:0] rdWordData = '0;
  logic        rdWordEnd = 1'b1;
  logic        rdWordTake, rdFrameTake;
  logic        wrFull = 1'b0;
  logic        wrWordPut, wrFrameCommit;
  logic [31:0] wrWordData;
  logic        cfgStb, cfgWe;
  logic [23:0] cfgAddr;
  logic [7:0]  cfgSel;
  logic [63:0] cfgWrData;
  logic [63:0] cfgRdData = '0;
  logic        cfgAck = 1'b0;

  always #5 clk = ~clk;

  maint_cfg_responder u0 (.*);

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inbound frame buffer model
  int          frameLens[$];
  logic [31:0] frameWords[$];
  int          rdIdx = 0;

  always @(negedge clk) begin
    if (frameLens.size() == 0) begin
      rdFrameEmpty = 1'b1; rdWordEnd = 1'b1; rdWordData = '0;
    end else begin
      rdFrameEmpty = 1'b0;
      rdWordEnd    = (rdIdx >= frameLens[0]);
      rdWordData   = rdWordEnd ? 32'h0 : frameWords[rdIdx];
    end
  end

  always @(posedge clk) begin
    if (rdWordTake) rdIdx = rdIdx + 1;
    if (rdFrameTake && frameLens.size() != 0) begin
      for (int i = 0; i < frameLens[0]; i++) void'(frameWords.pop_front());
      void'(frameLens.pop_front());
      rdIdx = 0;
    end
  end

  // expected outbound stream
  logic [31:0] expWord[$];
  bit          expCommit[$];
  string       expTag[$];
  int          putWhileFull = 0;

  always @(negedge clk) begin
    if (rstN && wrWordPut) begin
      if (wrFull) putWhileFull++;
      if (expWord.size() == 0 || expCommit[0]) begin
        check(0, "R9 unexpected response word", {32'h0, wrWordData}, 64'h0);
      end else begin
        check(wrWordData === expWord[0], expTag[0], {32'h0, wrWordData}, {32'h0, expWord[0]});
        void'(expWord.pop_front()); void'(expCommit.pop_front()); void'(expTag.pop_front());
      end
    end
    if (rstN && wrFrameCommit) begin
      if (expWord.size() == 0 || !expCommit[0]) begin
        check(0, "R10 commit out of place", 64'h1, 64'h0);
      end else begin
        check(1, "R10", 64'h1, 64'h1);
        void'(expWord.pop_front()); void'(expCommit.pop_front()); void'(expTag.pop_front());
      end
    end
  end

  // config bus responder
  bit          cWe[$];
  logic [23:0] cAddr[$];
  logic [7:0]  cSel[$];
  logic [63:0] cWd[$];
  logic [63:0] cRd[$];
  int          stbCycles = 0;

  always @(negedge clk) begin
    cfgAck = 1'b0;
    if (rstN && cfgStb) begin
      if (cWe.size() == 0) begin
        check(0, "R9 unexpected config access", {40'h0, cfgAddr}, 64'h0);
      end else begin
        check(cfgWe === cWe[0], "R3 R4 write enable", {63'h0, cfgWe}, {63'h0, cWe[0]});
        check(cfgAddr === cAddr[0], "R3 address", {40'h0, cfgAddr}, {40'h0, cAddr[0]});
        check(cfgSel === cSel[0], "R3 byte select", {56'h0, cfgSel}, {56'h0, cSel[0]});
        if (cWe[0]) check(cfgWrData === cWd[0], "R4 write data", cfgWrData, cWd[0]);
        if (stbCycles == 2) begin
          cfgAck = 1'b1;
          cfgRdData = cRd[0];
          void'(cWe.pop_front()); void'(cAddr.pop_front()); void'(cSel.pop_front());
          void'(cWd.pop_front()); void'(cRd.pop_front());
        end
      end
      stbCycles++;
    end else begin
      stbCycles = 0;
    end
  end

  function automatic logic [31:0] hdr0(input logic [3:0] ft, input logic [15:0] dst);
    return {5'b0, 1'b0, 1'b0, 2'b00, 2'b01, ft, 1'b0, dst};
  endfunction

  task automatic pushExp(input logic [31:0] w, input string tag);
    expWord.push_back(w); expCommit.push_back(0); expTag.push_back(tag);
  endtask

  task automatic pushCommit();
    expWord.push_back(32'h0); expCommit.push_back(1); expTag.push_back("R10");
  endtask

  task automatic sendRead(input logic [15:0] dst, input logic [15:0] src, input logic [7:0] tid,
                          input logic [23:0] addr, input logic [63:0] rdVal, input bit extra);
    frameWords.push_back(hdr0(4'd8, dst));
    frameWords.push_back({src, 4'h0, 4'h8, tid});
    frameWords.push_back({8'h05, addr[23:3], addr[2], 2'b00});
    if (extra) frameWords.push_back(32'hA5A5_5A5A);
    cWe.push_back(0); cAddr.push_back({addr[23:2], 2'b00});
    cSel.push_back(addr[2] ? 8'h0F : 8'hF0); cWd.push_back(64'h0); cRd.push_back(rdVal);
    pushExp({16'h0030, src}, "R7 word0");
    pushExp({dst, 4'h2, 4'h0, tid}, "R5 R7 word1");
    pushExp(32'hFF00_0000, "R7 word2");
    pushExp(addr[2] ? 32'h0 : rdVal[63:32], "R5 payload upper");
    pushExp(addr[2] ? rdVal[31:0] : 32'h0, "R5 payload lower");
    pushCommit();
    frameLens.push_back(extra ? 4 : 3);
  endtask

  task automatic sendWrite(input logic [15:0] dst, input logic [15:0] src, input logic [7:0] tid,
                           input logic [23:0] addr, input logic [31:0] data);
    frameWords.push_back(hdr0(4'd8, dst));
    frameWords.push_back({src, 4'h1, 4'h8, tid});
    frameWords.push_back({8'h00, addr[23:3], addr[2], 2'b00});
    frameWords.push_back(addr[2] ? 32'h0 : data);
    frameWords.push_back(addr[2] ? data : 32'h0);
    cWe.push_back(1); cAddr.push_back({addr[23:2], 2'b00});
    cSel.push_back(addr[2] ? 8'h0F : 8'hF0);
    cWd.push_back(addr[2] ? {32'h0, data} : {data, 32'h0}); cRd.push_back(64'h0);
    pushExp({16'h0030, src}, "R7 word0");
    pushExp({dst, 4'h3, 4'h0, tid}, "R6 R7 word1");
    pushExp(32'hFF00_0000, "R7 word2");
    pushCommit();
    frameLens.push_back(5);
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (expWord.size() == 0 && frameLens.size() == 0 && cWe.size() == 0) break;
    end
    @(negedge clk);
    check(expWord.size() == 0, "R5 R6 responses complete", 64'(expWord.size()), 64'h0);
    check(frameLens.size() == 0, "R2 frames consumed", 64'(frameLens.size()), 64'h0);
    check(cWe.size() == 0, "R3 R4 accesses complete", 64'(cWe.size()), 64'h0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset, no word taken while empty
    check({rdWordTake, rdFrameTake, cfgStb, cfgWe, wrWordPut, wrFrameCommit} == 6'b0,
          "R1 strobes after reset",
          {58'h0, rdWordTake, rdFrameTake, cfgStb, cfgWe, wrWordPut, wrFrameCommit}, 64'h0);
    begin
      int takes = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (rdWordTake || rdFrameTake) takes++;
      end
      check(takes == 0, "R1 idle while empty", 64'(takes), 64'h0);
    end

    sendRead(16'h0000, 16'h0002, 8'h06, 24'h010000, 64'h1122_3344_5566_7788, 0);
    drain();
    sendRead(16'h0ABC, 16'h1234, 8'h42, 24'h7FFFFC, 64'hDEAD_BEEF_CAFE_F00D, 0);
    drain();
    sendWrite(16'h0000, 16'h0002, 8'h07, 24'h010000, 32'hC0DE_BABE);
    drain();
    sendWrite(16'hBEEF, 16'h0F0F, 8'hFE, 24'h123454, 32'h8765_4321);
    drain();

    // R9: wrong format type, wrong transaction, truncated write: all dropped
    frameWords.push_back(hdr0(4'd5, 16'h1111));
    frameWords.push_back({16'h2222, 4'h0, 4'h8, 8'h01});
    frameWords.push_back(32'h0000_0100);
    frameLens.push_back(3);
    frameWords.push_back(hdr0(4'd8, 16'h1111));
    frameWords.push_back({16'h2222, 4'h4, 4'h8, 8'h02});
    frameWords.push_back(32'h0000_0100);
    frameLens.push_back(3);
    frameWords.push_back(hdr0(4'd8, 16'h1111));
    frameWords.push_back({16'h2222, 4'h1, 4'h8, 8'h03});
    frameWords.push_back(32'h0000_0100);
    frameLens.push_back(3);
    sendRead(16'h3333, 16'h4444, 8'h09, 24'h000008, 64'h0102_0304_0506_0708, 0);
    drain();

    // R2: trailing extra word drained before release
    sendRead(16'h5555, 16'h6666, 8'h0A, 24'h00FF04, 64'hAAAA_BBBB_CCCC_DDDD, 1);
    drain();

    // R8: response waits while the write port is full
    wrFull = 1'b1;
    sendWrite(16'h7777, 16'h8888, 8'h0B, 24'h000010, 32'h1357_9BDF);
    repeat (40) @(negedge clk);
    check(putWhileFull == 0, "R8 no word while full", 64'(putWhileFull), 64'h0);
    check(expWord.size() == 4, "R8 response held back", 64'(expWord.size()), 64'h4);
    wrFull = 1'b0;
    drain();

    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finish();
  end
endmodule